// File: doc/BRIEF.md
# Programmable PWM Generator with Atomic Reload

This block produces a pulse-width-modulated output whose high time and low time are each a 16-bit count of 1 µs ticks. Software loads the two counts one byte at a time through a simple write port. The bytes collect in holding registers. Only the write of the most significant byte of the high time takes all four bytes into a staged pair of values. The staged pair then replaces the running values at the start of the next high phase, so a waveform never mixes an old count with a new one.

The generator repeats its high/low period continuously or, in one-shot mode, produces a single period and then rests low. An enable input starts and stops it. Its output may optionally be ANDed with an external gate signal. All phase movement happens on a single-cycle clock-enable tick that the surrounding logic supplies once per microsecond.

Top module: `pwm_gen_top`

## Requirements
- R1: After reset the output is low, all held bytes and running counts are zero, and nothing is pending. Enabling without any commit therefore keeps the output low.
- R2: Byte addresses are fixed. Address 0 holds low-time bits 7:0, address 1 holds low-time bits 15:8, address 2 holds high-time bits 7:0, and address 3 holds high-time bits 15:8. Writes to addresses 0 to 2 alone never change the waveform. A write to address 3 commits all four bytes together.
- R3: In continuous mode, each period is a high phase of ON ticks followed by a low phase of OFF ticks, repeated. ON = 1 and OFF = 1 give a square wave that toggles every tick.
- R4: Phase changes happen only on a clock cycle with tick high. The first high phase after enabling begins at the first tick.
- R5: Clearing the enable drives the output low by the second clock edge and resets the phase counter. Enabling again begins with a full high phase.
- R6: In one-shot mode, one high phase and one low phase are produced and the output then stays low. It restarts only on a re-enable, or on a new commit, which begins a fresh period at the next tick.
- R7: An ON count of zero keeps the output low. An OFF count of zero with a nonzero ON count keeps the output high while enabled.
- R8: A commit made during a period does not affect that period. The new counts apply from the next period start. A commit on the same clock edge as a period start is applied at the start after that.
- R9: With the gate enable set, the output is the internal waveform ANDed with the gate input. With it clear, the gate input has no effect.
- R10: The output is registered. It follows the internal phase state one clock edge later, so the first high output appears two clock edges after the enabling tick edge is reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle 1 µs time base enable |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte register address |
| wr_data | input | 8 | Byte write data |
| ctl_enable | input | 1 | Run the generator |
| ctl_one_shot | input | 1 | 1 = single period, 0 = continuous |
| ctl_gate_en | input | 1 | AND the output with gate_in |
| gate_in | input | 1 | External gate signal |
| pwm_out | output | 1 | Registered PWM output |

## Verification
A commit write and a period start can land on the same clock edge. The staged values must then not be taken in that period, while the fresh commit must still remain pending for the following period. The bench measures the running period, places the address-3 write exactly on the edge where the low phase ends, and then judges the run lengths of the next two periods: old values first, new values second. A second collision, between a commit and the running high phase, is checked by showing that the interrupted period finishes with its old counts.

// File: rtl/pwm_gen_pkg.sv
// Package: shared types for the PWM generator.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_gen_pkg;

    // Phase of the waveform sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // disabled or waiting for the first tick
        PH_ON   = 2'd1,   // high phase
        PH_OFF  = 2'd2,   // low phase
        PH_DONE = 2'd3    // one-shot finished, resting low
    } phase_e;

endpackage

// File: rtl/pwm_shadow_regs.sv
// Module: byte-wide holding registers, staged pair and running pair.
// Writes to every byte except the top one land in holding registers.
// A write to the top byte builds the staged pair and raises pending.
// On reload with pending set, the staged pair becomes the running pair.
// Assumes: CNT_BYTES >= 1; byte layout is low-time bytes first, then high-time bytes.
module pwm_shadow_regs #(
    parameter int BYTE_W    = 8,
    parameter int CNT_BYTES = 2,
    localparam int CNT_W    = BYTE_W * CNT_BYTES,
    localparam int NUM_REGS = 2 * CNT_BYTES,
    localparam int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              reload,
    output logic [CNT_W-1:0]  act_on,
    output logic [CNT_W-1:0]  act_off,
    output logic              pend
);

    localparam logic [ADDR_W-1:0] COMMIT_IDX = ADDR_W'(NUM_REGS - 1);
    localparam int HELD_W = (NUM_REGS - 1) * BYTE_W;

    logic [HELD_W-1:0] held_flat;
    logic [CNT_W-1:0]  on_new;
    logic [CNT_W-1:0]  off_new;
    logic [CNT_W-1:0]  stg_on;
    logic [CNT_W-1:0]  stg_off;
    logic              commit;

    assign commit = wr_en && (wr_addr == COMMIT_IDX);

    // One holding register per byte address below the commit byte.
    for (genvar g = 0; g < NUM_REGS - 1; g++) begin : g_hold
        logic [BYTE_W-1:0] byte_q;
        // Capture the byte written to this address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                byte_q <= wr_data;
        end
        assign held_flat[g*BYTE_W +: BYTE_W] = byte_q;
    end

    // The high-time word takes its top byte straight from the write bus.
    if (CNT_BYTES == 1) begin : g_on_single
        assign on_new = wr_data;
    end else begin : g_on_multi
        assign on_new = {wr_data, held_flat[HELD_W-1:CNT_W]};
    end
    assign off_new = held_flat[CNT_W-1:0];

    // Commit: snapshot all bytes into the staged pair together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_on  <= '0;
            stg_off <= '0;
        end else if (commit) begin
            stg_on  <= on_new;
            stg_off <= off_new;
        end
    end

    // Pending flag: set by a commit, cleared when a reload consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (commit)
            pend <= 1'b1;
        else if (reload)
            pend <= 1'b0;
    end

    // Running pair: replaced only at a period start with a commit pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_on  <= '0;
            act_off <= '0;
        end else if (reload && pend) begin
            act_on  <= stg_on;
            act_off <= stg_off;
        end
    end

endmodule

// File: rtl/pwm_phase_ctrl.sv
// Module: high/low phase sequencer with tick-based counting.
// Moves between idle, high, low and done phases on tick cycles only.
// Requests a reload at every period start.
// Assumes: tick is a single-cycle enable; act_on/act_off update on the
// same edge that reload is accepted.
module pwm_phase_ctrl
    import pwm_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic             one_shot,
    input  logic             pend,
    input  logic [CNT_W-1:0] act_on,
    input  logic [CNT_W-1:0] act_off,
    output logic             reload,
    output logic             raw_pwm,
    output phase_e           phase
);

    phase_e           phase_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W:0]   cnt_inc;
    logic             last_on;
    logic             last_off;

    assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
    assign last_on  = (cnt_inc >= {1'b0, act_on});
    assign last_off = (cnt_inc >= {1'b0, act_off});

    // Next-phase and counter decision, including the period-start reload.
    always_comb begin
        phase_d = phase;
        cnt_d   = cnt_q;
        reload  = 1'b0;
        if (!enable) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
        end else if (tick) begin
            unique case (phase)
                PH_IDLE: begin
                    phase_d = PH_ON;
                    cnt_d   = '0;
                    reload  = 1'b1;
                end
                PH_ON: begin
                    if (!last_on) begin
                        cnt_d = cnt_q + 1'b1;
                    end else if (act_off != '0) begin
                        phase_d = PH_OFF;
                        cnt_d   = '0;
                    end else if (one_shot) begin
                        phase_d = PH_DONE;
                        cnt_d   = '0;
                    end else begin
                        phase_d = PH_ON;
                        cnt_d   = '0;
                        reload  = 1'b1;
                    end
                end
                PH_OFF: begin
                    if (!last_off) begin
                        cnt_d = cnt_q + 1'b1;
                    end else if (one_shot) begin
                        phase_d = PH_DONE;
                        cnt_d   = '0;
                    end else begin
                        phase_d = PH_ON;
                        cnt_d   = '0;
                        reload  = 1'b1;
                    end
                end
                PH_DONE: begin
                    if (pend) begin
                        phase_d = PH_ON;
                        cnt_d   = '0;
                        reload  = 1'b1;
                    end
                end
                default: begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            phase <= phase_d;
            cnt_q <= cnt_d;
        end
    end

    // Internal waveform: high only in the high phase with a nonzero count.
    assign raw_pwm = (phase == PH_ON) && (act_on != '0);

endmodule

// File: rtl/pwm_out_gate.sv
// Module: optional AND gating and the output register.
// Assumes: gate_in is already synchronous to clk.
module pwm_out_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_pwm,
    input  logic gate_en,
    input  logic gate_in,
    output logic pwm_out
);

    logic gate_ok;

    assign gate_ok = gate_en ? gate_in : 1'b1;

    // Register the gated waveform so the pin never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_out <= 1'b0;
        else
            pwm_out <= raw_pwm && gate_ok;
    end

endmodule

// File: rtl/pwm_gen_top.sv
// Module: top of the PWM generator with atomic reload.
// Joins byte storage, the phase sequencer and the output gate.
// Assumes: tick arrives once per microsecond as a one-cycle pulse.
module pwm_gen_top
    import pwm_gen_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int CNT_BYTES = 2,
    localparam int CNT_W    = BYTE_W * CNT_BYTES,
    localparam int ADDR_W   = $clog2(2 * CNT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ctl_enable,
    input  logic              ctl_one_shot,
    input  logic              ctl_gate_en,
    input  logic              gate_in,
    output logic              pwm_out
);

    logic [CNT_W-1:0] act_on;
    logic [CNT_W-1:0] act_off;
    logic             pend;
    logic             reload;
    logic             raw_pwm;
    phase_e           phase;

    pwm_shadow_regs #(
        .BYTE_W    (BYTE_W),
        .CNT_BYTES (CNT_BYTES)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .reload  (reload),
        .act_on  (act_on),
        .act_off (act_off),
        .pend    (pend)
    );

    pwm_phase_ctrl #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .enable   (ctl_enable),
        .one_shot (ctl_one_shot),
        .pend     (pend),
        .act_on   (act_on),
        .act_off  (act_off),
        .reload   (reload),
        .raw_pwm  (raw_pwm),
        .phase    (phase)
    );

    pwm_out_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_pwm (raw_pwm),
        .gate_en (ctl_gate_en),
        .gate_in (gate_in),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwm_gen_checker.sv
// Module: temporal checks for pwm_gen_top, attached by bind.
// Assumes: synchronous active-low reset; observes ports and internal joins.
module pwm_gen_checker
    import pwm_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ctl_enable,
    input logic             ctl_gate_en,
    input logic             gate_in,
    input logic             pwm_out,
    input logic             reload,
    input logic [CNT_W-1:0] act_on,
    input logic [CNT_W-1:0] act_off,
    input phase_e           phase
);

    // R5: a disable seen last edge forces the output low one edge later.
    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctl_enable) |=> !pwm_out);

    // R9: a closed gate blocks the output on the next edge.
    assert_gate_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_gate_en && !gate_in) |=> !pwm_out);

    // R8: running counts change only when a period start was requested.
    assert_counts_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_on) || !$stable(act_off)) |-> $past(reload));

    // R4: while enabled, the phase moves only on a tick cycle.
    assert_phase_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(phase) && $past(ctl_enable)) |-> $past(tick));

    // R10: a rising output traces back to enable two edges earlier.
    assert_rise_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> $past(ctl_enable, 2));

endmodule

bind pwm_gen_top pwm_gen_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .ctl_enable  (ctl_enable),
    .ctl_gate_en (ctl_gate_en),
    .gate_in     (gate_in),
    .pwm_out     (pwm_out),
    .reload      (reload),
    .act_on      (act_on),
    .act_off     (act_off),
    .phase       (phase)
);

// File: tb/pwm_gen_top_bench.sv
// Directed bench for pwm_gen_top: one task per scenario.
module pwm_gen_top_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       ctl_enable;
    logic       ctl_one_shot;
    logic       ctl_gate_en;
    logic       gate_in;
    logic       pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_div = 1;
    int tick_cnt = 0;

    always #5 clk = ~clk;

    // Time base: tick high one cycle in every tick_div, changed at negedge.
    always @(negedge clk) begin
        if (tick_cnt + 1 >= tick_div) begin
            tick     <= 1'b1;
            tick_cnt <= 0;
        end else begin
            tick     <= 1'b0;
            tick_cnt <= tick_cnt + 1;
        end
    end

    pwm_gen_top u_pwm_gen_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ctl_enable   (ctl_enable),
        .ctl_one_shot (ctl_one_shot),
        .ctl_gate_en  (ctl_gate_en),
        .gate_in      (gate_in),
        .pwm_out      (pwm_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Byte write, called at a negedge; returns at the next negedge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic program_counts(input int on_t, input int off_t);
        wr(2'd0, off_t[7:0]);
        wr(2'd1, off_t[15:8]);
        wr(2'd2, on_t[7:0]);
        wr(2'd3, on_t[15:8]);
    endtask

    // Count consecutive negedge samples equal to lvl, up to lim.
    task automatic count_level(input logic lvl, input int lim, output int n);
        n = 0;
        while (pwm_out == lvl && n < lim) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic sync_rise();
        int n;
        count_level(1'b1, 400, n);
        count_level(1'b0, 400, n);
    endtask

    task automatic settle();
        sync_rise();
        sync_rise();
    endtask

    task automatic t_reset();
        int n;
        chk("R1 output low after reset", pwm_out, 0);
        ctl_enable = 1'b1;
        repeat (4) @(negedge clk);
        count_level(1'b0, 20, n);
        chk("R1 enable with no commit stays low", n, 20);
        ctl_enable = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_basic();
        int n, h, l;
        program_counts(3, 2);
        ctl_enable = 1'b1;
        @(negedge clk);
        count_level(1'b0, 50, n);
        chk("R10 first high after enable", n, 1);
        count_level(1'b1, 50, h);
        chk("R4 full first high phase", h, 3);
        count_level(1'b0, 50, l);
        chk("R3 low phase", l, 2);
        count_level(1'b1, 50, h);
        chk("R3 repeated high phase", h, 3);
        program_counts(1, 1);
        settle();
        count_level(1'b1, 50, h);
        count_level(1'b0, 50, l);
        chk("R3 fastest high", h, 1);
        chk("R3 fastest low", l, 1);
    endtask

    task automatic t_no_commit();
        int h, l;
        program_counts(2, 2);
        settle();
        wr(2'd0, 8'd1);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'd4);
        settle();
        count_level(1'b1, 50, h);
        count_level(1'b0, 50, l);
        chk("R2 held bytes no effect high", h, 2);
        chk("R2 held bytes no effect low", l, 2);
        wr(2'd3, 8'd0);
        settle();
        count_level(1'b1, 50, h);
        count_level(1'b0, 50, l);
        chk("R2 commit byte map high", h, 4);
        chk("R2 commit byte map low", l, 1);
    endtask

    task automatic t_mid_commit();
        int h, l;
        program_counts(4, 4);
        wr(2'd0, 8'd6);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'd2);
        settle();
        wr(2'd3, 8'd0);
        count_level(1'b1, 50, h);
        chk("R8 current high keeps old count", h + 1, 4);
        count_level(1'b0, 50, l);
        chk("R8 current low keeps old count", l, 4);
        count_level(1'b1, 50, h);
        count_level(1'b0, 50, l);
        chk("R8 next high uses new count", h, 2);
        chk("R8 next low uses new count", l, 6);
    endtask

    task automatic t_collision();
        int n, h, l;
        program_counts(2, 2);
        wr(2'd0, 8'd1);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'd5);
        settle();
        repeat (2) @(negedge clk);
        wr(2'd3, 8'd0);
        count_level(1'b0, 50, n);
        count_level(1'b1, 50, h);
        count_level(1'b0, 50, l);
        chk("R8 same-edge commit old high", h, 2);
        chk("R8 same-edge commit old low", l, 2);
        count_level(1'b1, 50, h);
        count_level(1'b0, 50, l);
        chk("R8 same-edge commit later high", h, 5);
        chk("R8 same-edge commit later low", l, 1);
    endtask

    task automatic t_oneshot();
        int n, h;
        ctl_enable = 1'b0;
        ctl_one_shot = 1'b1;
        program_counts(3, 2);
        ctl_enable = 1'b1;
        @(negedge clk);
        count_level(1'b0, 50, n);
        count_level(1'b1, 50, h);
        chk("R6 one-shot high", h, 3);
        count_level(1'b0, 40, n);
        chk("R6 one-shot rests low", n, 40);
        program_counts(2, 1);
        count_level(1'b0, 50, n);
        count_level(1'b1, 50, h);
        chk("R6 commit restarts one-shot", h, 2);
        count_level(1'b0, 40, n);
        chk("R6 rests low after restart", n, 40);
        ctl_enable = 1'b0;
        repeat (3) @(negedge clk);
        ctl_enable = 1'b1;
        @(negedge clk);
        count_level(1'b0, 50, n);
        count_level(1'b1, 50, h);
        chk("R6 re-enable restarts one-shot", h, 2);
        ctl_one_shot = 1'b0;
    endtask

    task automatic t_zero();
        int n;
        program_counts(0, 3);
        repeat (12) @(negedge clk);
        count_level(1'b0, 50, n);
        chk("R7 zero high time stays low", n, 50);
        program_counts(3, 0);
        repeat (12) @(negedge clk);
        count_level(1'b1, 50, n);
        chk("R7 zero low time stays high", n, 50);
    endtask

    task automatic t_disable();
        int n, h;
        program_counts(5, 3);
        settle();
        @(negedge clk);
        ctl_enable = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 disabled output low", pwm_out, 0);
        count_level(1'b0, 10, n);
        chk("R5 stays low while disabled", n, 10);
        ctl_enable = 1'b1;
        @(negedge clk);
        count_level(1'b0, 50, n);
        count_level(1'b1, 50, h);
        chk("R5 re-enable full high phase", h, 5);
    endtask

    task automatic t_gate();
        int n, h, l;
        program_counts(2, 2);
        settle();
        ctl_gate_en = 1'b1;
        gate_in = 1'b0;
        repeat (2) @(negedge clk);
        count_level(1'b0, 30, n);
        chk("R9 closed gate blocks output", n, 30);
        gate_in = 1'b1;
        settle();
        count_level(1'b1, 50, h);
        count_level(1'b0, 50, l);
        chk("R9 open gate passes high", h, 2);
        chk("R9 open gate passes low", l, 2);
        ctl_gate_en = 1'b0;
        gate_in = 1'b0;
        settle();
        count_level(1'b1, 50, h);
        chk("R9 gate ignored when off", h, 2);
    endtask

    task automatic t_tick();
        int h, l;
        tick_div = 3;
        program_counts(2, 1);
        settle();
        count_level(1'b1, 100, h);
        count_level(1'b0, 100, l);
        chk("R4 high spans ticks", h, 6);
        chk("R4 low spans ticks", l, 3);
        tick_div = 1;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst_n = 1'b0;
        wr_en = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        ctl_enable = 1'b0;
        ctl_one_shot = 1'b0;
        ctl_gate_en = 1'b0;
        gate_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_no_commit();
        t_mid_commit();
        t_collision();
        t_zero();
        t_disable();
        t_gate();
        t_tick();
        t_oneshot();
        report();
    end

endmodule